// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block produces the serial timing clocks for an audio output path from a single master audio clock. Three master clock pins are provided, one for each sample-rate family (32 kHz, 44.1 kHz and 48 kHz). A 2-bit source field chooses which pin drives the divider chain. A 4-bit ratio code tells the block how many times faster than the sample rate Fs that master clock runs.

From the chosen master clock the block derives four clocks. The first is a 128×Fs bit clock for a biphase-coded digital audio transmitter. The second is a 64×Fs bit clock for external converters. The third is an Fs left/right word clock. The fourth is an oversampled master clock for the converters at 256×Fs or 384×Fs. All of them come from one phase counter. They are registered in the master-clock domain, except for the converter master clock, which is the master clock itself when no division is needed.

Both fields come from host configuration registers and may change at any time. Any change restarts the divider chain cleanly, so that the word clock always begins on the left channel.

Top module: `audio_clkgen`

## Requirements
- R1: `src_sel` picks the master clock: 0 selects `mclk_32k`, 1 selects `mclk_44k`, and 2 or 3 select `mclk_48k`.
- R2: While `rst` is high, and on the first master edge after it falls, the divider runs from `mclk_48k` whatever `src_sel` holds.
- R3: `div_code` sets the master oversampling factor N as follows: 0 means 256, 1 means 384, 2 means 512, and 3 or 4 mean 768. Codes 5 to 15 behave as code 2.
- R4: `spdif_bclk` has a period of N/128 master cycles and is high for floor(N/256) of them. At N=384 this gives 1 high cycle in 3.
- R5: `spdif_bclk` falls on the same master edge as every rising and every falling edge of `dac_bclk`.
- R6: `dac_bclk` has a period of N/64 master cycles with equal high and low halves.
- R7: `dac_lrck` has a period of N master cycles. It changes only on the master edge where `dac_bclk` falls, and only after 32 full `dac_bclk` periods since its last change.
- R8: `dac_mclk` follows the master clock for codes 0 and 1. It is the master clock divided by 2 for codes 2, 4 and 5 to 15. It is divided by 3, high one cycle in three, for code 3.
- R9: A change of `src_sel` or `div_code` restarts the chain: on the next master edge `spdif_bclk`, `dac_bclk` and `dac_lrck` go low, and `dac_lrck` then stays low for 32 `dac_bclk` periods.
- R10: The synchronous active-high `rst` holds `spdif_bclk`, `dac_bclk` and `dac_lrck` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high reset, sampled by the selected master clock |
| mclk_32k | input | 1 | Master clock for the 32 kHz family |
| mclk_44k | input | 1 | Master clock for the 44.1 kHz family |
| mclk_48k | input | 1 | Master clock for the 48 kHz family, the reset default |
| src_sel | input | 2 | Master clock source field |
| div_code | input | 4 | Master oversampling ratio code |
| spdif_bclk | output | 1 | 128×Fs transmitter bit clock |
| dac_bclk | output | 1 | 64×Fs converter bit clock |
| dac_lrck | output | 1 | Fs word clock, low for left |
| dac_mclk | output | 1 | 256×Fs or 384×Fs converter master clock |

## Verification
The word-clock toggle and the falling edge of the converter bit clock must land on the same master edge, and the transmitter bit clock must fall on that edge as well. The bench provokes this coincidence for every ratio code and every source. It measures the edge times of all outputs against periods and high times computed from the sample-rate multiple. It also samples just after each converter bit-clock edge to confirm that the transmitter clock is low there. The second collision is a configuration change made while the word clock is high. The bench waits for a word-clock rising edge, changes a field at once, and checks that the restart wins: the word clock is low a few master cycles later.

// File: rtl/aclkgen_pkg.sv
`timescale 1ns/1ps
package aclkgen_pkg;
    localparam int SEL_W     = 2;
    localparam int CODE_W    = 4;
    localparam int HALF_W    = 3;              // master cycles per half converter bit, max 6
    localparam int CNT_W     = HALF_W + 1;     // phase counter spans one converter bit
    localparam int SLOT_BITS = 32;             // converter bits per channel slot
    localparam int SLOT_W    = $clog2(SLOT_BITS);
    localparam int MDIV_W    = 2;

    typedef enum logic [SEL_W-1:0] {
        SRC_32K     = 2'd0,
        SRC_44K     = 2'd1,
        SRC_48K     = 2'd2,
        SRC_48K_ALT = 2'd3
    } src_e;

    typedef enum logic [1:0] {
        MCK_PASS = 2'd0,
        MCK_DIV2 = 2'd1,
        MCK_DIV3 = 2'd2
    } mck_e;

    typedef struct packed {
        logic [HALF_W-1:0] half;   // N/128: master cycles per half converter bit
        mck_e              mck;    // how the converter master clock is formed
    } ratio_t;

    function automatic ratio_t decode_ratio(input logic [CODE_W-1:0] code);
        ratio_t r;
        case (code)
            4'd0:    r = '{half: 3'd2, mck: MCK_PASS};   // 256 x Fs
            4'd1:    r = '{half: 3'd3, mck: MCK_PASS};   // 384 x Fs
            4'd3:    r = '{half: 3'd6, mck: MCK_DIV3};   // 768 x Fs, 256 x Fs out
            4'd4:    r = '{half: 3'd6, mck: MCK_DIV2};   // 768 x Fs, 384 x Fs out
            default: r = '{half: 3'd4, mck: MCK_DIV2};   // 512 x Fs
        endcase
        return r;
    endfunction
endpackage

// File: rtl/aclkgen_srcsel.sv
`timescale 1ns/1ps
module aclkgen_srcsel
    import aclkgen_pkg::*;
(
    input  logic              rst,
    input  logic              mclk_32k,
    input  logic              mclk_44k,
    input  logic              mclk_48k,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [CODE_W-1:0] div_code,
    output logic              mclk,
    output logic              restart,
    output ratio_t            cfg
);
    src_e              sel_q;
    logic [CODE_W-1:0] code_q;

    always_comb begin
        case (sel_q)
            SRC_32K: mclk = mclk_32k;
            SRC_44K: mclk = mclk_44k;
            default: mclk = mclk_48k;
        endcase
    end

    always_ff @(posedge mclk) begin
        if (rst) begin
            sel_q  <= SRC_48K;
            code_q <= '0;
        end else begin
            sel_q  <= src_e'(src_sel);
            code_q <= div_code;
        end
    end

    assign restart = !rst && ((sel_q != src_e'(src_sel)) || (code_q != div_code));
    assign cfg     = decode_ratio(code_q);
endmodule

// File: rtl/aclkgen_bitdiv.sv
`timescale 1ns/1ps
module aclkgen_bitdiv
    import aclkgen_pkg::*;
(
    input  logic   clk,
    input  logic   clr,
    input  ratio_t ratio,
    output logic   spdif_o,
    output logic   dac_o,
    output logic   mck_o,
    output logic   bit_end_o
);
    logic [CNT_W-1:0]  cnt, cnt_nxt, half_x, last, rem_nxt, spd_thr;
    logic [MDIV_W-1:0] mc, mc_nxt, mc_lim;

    assign half_x  = CNT_W'(ratio.half);
    assign last    = (half_x << 1) - CNT_W'(1);
    assign cnt_nxt = (cnt == last) ? '0 : cnt + CNT_W'(1);
    assign rem_nxt = (cnt_nxt >= half_x) ? (cnt_nxt - half_x) : cnt_nxt;
    assign spd_thr = half_x - (half_x >> 1);

    assign mc_lim  = (ratio.mck == MCK_DIV3) ? MDIV_W'(2) : MDIV_W'(1);
    assign mc_nxt  = (mc == mc_lim) ? '0 : mc + MDIV_W'(1);

    always_ff @(posedge clk) begin
        if (clr) begin
            cnt     <= '0;
            mc      <= '0;
            dac_o   <= 1'b0;
            spdif_o <= 1'b0;
            mck_o   <= 1'b0;
        end else begin
            cnt     <= cnt_nxt;
            mc      <= mc_nxt;
            dac_o   <= (cnt_nxt >= half_x);
            spdif_o <= (rem_nxt >= spd_thr);
            mck_o   <= (mc_nxt == mc_lim);
        end
    end

    // last phase of a converter bit: its clock falls on the coming edge
    assign bit_end_o = (cnt == last);
endmodule

// File: rtl/aclkgen_worddiv.sv
`timescale 1ns/1ps
module aclkgen_worddiv
    import aclkgen_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic bit_end,
    output logic lrck_o
);
    logic [SLOT_W-1:0] slot;

    always_ff @(posedge clk) begin
        if (clr) begin
            slot   <= '0;
            lrck_o <= 1'b0;
        end else if (bit_end) begin
            if (slot == SLOT_W'(SLOT_BITS - 1)) begin
                slot   <= '0;
                lrck_o <= ~lrck_o;
            end else begin
                slot   <= slot + SLOT_W'(1);
            end
        end
    end
endmodule

// File: rtl/audio_clkgen.sv
`timescale 1ns/1ps
module audio_clkgen
    import aclkgen_pkg::*;
(
    input  logic              rst,
    input  logic              mclk_32k,
    input  logic              mclk_44k,
    input  logic              mclk_48k,
    input  logic [SEL_W-1:0]  src_sel,
    input  logic [CODE_W-1:0] div_code,
    output logic              spdif_bclk,
    output logic              dac_bclk,
    output logic              dac_lrck,
    output logic              dac_mclk
);
    logic   mclk, restart, clr, bit_end, mck_div;
    ratio_t cfg;

    aclkgen_srcsel u_src (
        .rst      (rst),
        .mclk_32k (mclk_32k),
        .mclk_44k (mclk_44k),
        .mclk_48k (mclk_48k),
        .src_sel  (src_sel),
        .div_code (div_code),
        .mclk     (mclk),
        .restart  (restart),
        .cfg      (cfg)
    );

    assign clr = rst || restart;

    aclkgen_bitdiv u_bit (
        .clk       (mclk),
        .clr       (clr),
        .ratio     (cfg),
        .spdif_o   (spdif_bclk),
        .dac_o     (dac_bclk),
        .mck_o     (mck_div),
        .bit_end_o (bit_end)
    );

    aclkgen_worddiv u_word (
        .clk     (mclk),
        .clr     (clr),
        .bit_end (bit_end),
        .lrck_o  (dac_lrck)
    );

    assign dac_mclk = (cfg.mck == MCK_PASS) ? mclk : mck_div;
endmodule

// File: rtl/audio_clkgen_chk.sv
`timescale 1ns/1ps
module audio_clkgen_chk
    import aclkgen_pkg::*;
(
    input logic mclk,
    input logic rst,
    input logic restart,
    input logic spdif_bclk,
    input logic dac_bclk,
    input logic dac_lrck
);
    logic       rs_d, dac_d, lr_d;
    logic [5:0] falls;

    always_ff @(posedge mclk) begin
        rs_d  <= rst || restart;
        dac_d <= dac_bclk;
        lr_d  <= dac_lrck;
        if (rst || restart || rs_d || (dac_lrck != lr_d))
            falls <= '0;
        else if (dac_d && !dac_bclk)
            falls <= falls + 6'd1;
    end

    AST_LRCK_ON_BCLK_FALL: assert property (@(posedge mclk) disable iff (rst || restart || rs_d)
        !$stable(dac_lrck) |-> $fell(dac_bclk)); // R7

    AST_LRCK_SLOT_LENGTH: assert property (@(posedge mclk) disable iff (rst || restart || rs_d)
        (dac_lrck != lr_d) |-> (falls == 6'(SLOT_BITS - 1))); // R7

    AST_SPDIF_ALIGNED: assert property (@(posedge mclk) disable iff (rst || restart || rs_d)
        !$stable(dac_bclk) |-> $fell(spdif_bclk)); // R5

    AST_RESTART_LOW: assert property (@(posedge mclk) disable iff (rst)
        restart |=> (!dac_lrck && !dac_bclk && !spdif_bclk)); // R9
endmodule

bind audio_clkgen audio_clkgen_chk u_chk (
    .mclk       (mclk),
    .rst        (rst),
    .restart    (restart),
    .spdif_bclk (spdif_bclk),
    .dac_bclk   (dac_bclk),
    .dac_lrck   (dac_lrck)
);

// File: tb/sim_audio_clkgen.sv
`timescale 1ns/1ps
module sim_audio_clkgen;
    logic       rst = 1'b1;
    logic       mclk_32k = 1'b0, mclk_44k = 1'b0, mclk_48k = 1'b0;
    logic [1:0] src_sel = 2'd0;
    logic [3:0] div_code = 4'd0;
    logic       spdif_bclk, dac_bclk, dac_lrck, dac_mclk;

    int checks = 0;
    int errors = 0;
    bit busy = 1'b0;
    bit done = 1'b0;

    typedef struct {
        int      sig;      // 0 spdif, 1 dac bit, 2 word, 3 dac master
        realtime per;
        realtime hi;
        string   req;
    } item_t;
    item_t sb[$];

    always #10 mclk_48k = ~mclk_48k;   // 50 MHz
    always #11 mclk_44k = ~mclk_44k;
    always #15 mclk_32k = ~mclk_32k;

    audio_clkgen u0 (
        .rst(rst), .mclk_32k(mclk_32k), .mclk_44k(mclk_44k), .mclk_48k(mclk_48k),
        .src_sel(src_sel), .div_code(div_code),
        .spdif_bclk(spdif_bclk), .dac_bclk(dac_bclk), .dac_lrck(dac_lrck), .dac_mclk(dac_mclk)
    );

    task automatic chk_time(input string req, input string what, input realtime act, input realtime exp);
        checks++;
        if (act > exp + 0.01 || act < exp - 0.01) begin
            errors++;
            $display("FAIL %s %s: actual %0.2f ns expected %0.2f ns", req, what, act, exp);
        end
    endtask

    task automatic chk_bit(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic wait_edge(input int s, input bit rise);
        case (s)
            0: if (rise) @(posedge spdif_bclk); else @(negedge spdif_bclk);
            1: if (rise) @(posedge dac_bclk);   else @(negedge dac_bclk);
            2: if (rise) @(posedge dac_lrck);   else @(negedge dac_lrck);
            default: if (rise) @(posedge dac_mclk); else @(negedge dac_mclk);
        endcase
    endtask

    task automatic push(input int s, input realtime per, input realtime hi, input string req);
        item_t it;
        it.sig = s; it.per = per; it.hi = hi; it.req = req;
        sb.push_back(it);
    endtask

    task automatic wait_idle();
        wait (sb.size() == 0 && !busy);
    endtask

    // monitor: pops expected items and measures the named output
    initial begin
        forever begin
            item_t   it;
            realtime t0, t1, t2;
            wait (sb.size() != 0);
            busy = 1'b1;
            it = sb.pop_front();
            wait_edge(it.sig, 1'b1); t0 = $realtime;
            wait_edge(it.sig, 1'b0); t1 = $realtime;
            wait_edge(it.sig, 1'b1); t2 = $realtime;
            chk_time(it.req, "period", t2 - t0, it.per);
            chk_time(it.req, "high time", t1 - t0, it.hi);
            busy = 1'b0;
        end
    end

    // driver: apply a configuration and queue the expected clock shapes
    task automatic apply(input logic [1:0] sel, input logic [3:0] code, input bit first);
        realtime tm, mp, mh;
        int      n, p;
        wait_idle();
        if (!first) @(posedge dac_lrck);
        #0.3;
        src_sel  = sel;
        div_code = code;
        if (!first) begin
            #160;
            chk_bit("R9", "word clock after restart", dac_lrck, 1'b0);
        end
        #400;
        tm = (sel == 2'd0) ? 30.0 : (sel == 2'd1) ? 22.0 : 20.0;              // R1
        case (code)                                                          // R3
            4'd0:       n = 256;
            4'd1:       n = 384;
            4'd3, 4'd4: n = 768;
            default:    n = 512;
        endcase
        p = n / 128;
        if (code == 4'd0 || code == 4'd1) begin mp = tm;       mh = tm / 2.0; end
        else if (code == 4'd3)            begin mp = 3.0 * tm; mh = tm;       end
        else                              begin mp = 2.0 * tm; mh = tm;       end
        push(0, p * tm, (p / 2) * tm, "R1 R3 R4");
        push(1, 2 * p * tm, p * tm, "R1 R3 R6");
        push(2, n * tm, (n / 2) * tm, "R1 R3 R7");
        push(3, mp, mh, "R1 R3 R8");
        wait_idle();
        @(posedge dac_bclk); #0.5;
        chk_bit("R5", "transmitter clock at bit clock rise", spdif_bclk, 1'b0);
        @(negedge dac_bclk); #0.5;
        chk_bit("R5", "transmitter clock at bit clock fall", spdif_bclk, 1'b0);
    endtask

    initial begin
        #100.3;
        chk_bit("R10", "transmitter clock in reset", spdif_bclk, 1'b0);
        chk_bit("R10", "bit clock in reset", dac_bclk, 1'b0);
        chk_bit("R10", "word clock in reset", dac_lrck, 1'b0);
        push(3, 20.0, 10.0, "R2");          // 48k source despite src_sel = 0
        wait_idle();
        #100.3;
        rst = 1'b0;
        apply(2'd2, 4'd2, 1'b1);
        apply(2'd0, 4'd0, 1'b0);
        apply(2'd1, 4'd1, 1'b0);
        apply(2'd3, 4'd3, 1'b0);
        apply(2'd2, 4'd4, 1'b0);
        apply(2'd0, 4'd9, 1'b0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule